// File: doc/BRIEF.md
# Page-Table Walk Step Unit

This unit performs one step of a software-sequenced page-table walk. Two kinds of command exist. A directory step takes an entry and a level number. It either hands the entry back (when the level is out of range or the entry describes a huge page) or fetches the next directory pointer from memory at an address built from the faulting virtual address. A leaf step takes an entry and an even/odd selector and produces one half of the translation pair that a TLB refill needs. It reads that half from a page table, or derives it arithmetically when the entry is a huge page.

Each level has its own index position and index width in a configuration vector. Slot 0 describes the last-level page table, and slots 1 to NLVL describe the directory levels. Memory is reached through a single-beat read port with a valid/ready request and a 64-bit response. Only one request is outstanding at a time. Every command ends with a one-cycle `done` pulse and the result on `res_data`. Leaf commands also update an even or an odd refill register and a recorded page size.

Entry bit positions used: bit 6 is the huge flag in directory entries and the global flag in leaf entries. Bit 12 is the huge-global flag. Bits [14:13] hold the huge-page level.

Top module: `ptw_step_unit`

## Requirements
- R1: A directory step whose level is 0 or greater than NLVL raises `done` on the cycle after acceptance, with `res_data` equal to `cmd_base` unchanged, and issues no memory request.
- R2: A directory step with level 1..NLVL whose base has bit 6 set issues no memory request. At level NLVL it returns the base unchanged. At any other level it returns the base unchanged if bits [14:13] are non-zero; otherwise it returns the base with bits [14:13] set to the level's two low bits. In every case `done` rises on the cycle after acceptance.
- R3: A directory step with level L in 1..NLVL and bit 6 clear requests address `(cmd_base & PA mask) | (idx << 3)`, where `idx = (fault_va >> shift[L]) & ((1 << width[L]) - 1)`. The result is the response word ANDed with the PA_W-bit mask, and `done` rises on the cycle after the response is taken.
- R4: A leaf step whose base has bit 6 clear takes `idx = (fault_va >> shift[0]) & ((1 << width[0]) - 1)`, clears bit 0 of it, adds 1 when odd, and requests `(cmd_base & PA mask) | (idx << 3)`. The result is the PA-masked response, and the recorded page size is `shift[0]`.
- R5: A huge leaf step (bit 6 set) masks the base to PA_W bits and clears bits 6, 13 and 14. If bit 12 was set, it clears bit 12 and sets bit 6. It makes no memory request and finishes on the cycle after acceptance.
- R6: For a huge leaf step, with `lv` = base bits [14:13], the page size is `shift[lv] + width[lv] - 1`. The odd half adds `1 << page size` to the formatted entry; the even half adds nothing.
- R7: A leaf result is written to `refill_odd` when the selector is 1 and to `refill_even` when it is 0, leaving the other register untouched, and `refill_ps` records the page size. Directory steps change neither refill register.
- R8: `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready`. While a request or response is pending, `cmd_ready` is low and `done` stays low.
- R9: After reset, `cmd_ready` is 1 and `done`, `mem_req_valid`, `res_data`, `refill_even`, `refill_odd` and `refill_ps` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit idle, command accepted when valid |
| cmd_leaf | input | 1 | 0 = directory step, 1 = leaf step |
| cmd_base | input | 64 | Base entry |
| cmd_level | input | LVL_W | Directory level (directory step only) |
| cmd_odd | input | 1 | Leaf half selector, 1 = odd |
| fault_va | input | VA_W | Faulting virtual address |
| lvl_shift_cfg | input | (NLVL+1)*6 | Index shift per level, slot 0 = page table |
| lvl_width_cfg | input | (NLVL+1)*6 | Index width per level, slot 0 = page table |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | PA_W | Read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | One-cycle completion pulse |
| res_data | output | 64 | Result of the last command |
| refill_even | output | 64 | Even refill half |
| refill_odd | output | 64 | Odd refill half |
| refill_ps | output | 6 | Page size of the last leaf result |

## Verification
Directory steps are swept over every level code from 0 to 7 against four virtual addresses chosen so that each level's index field differs. Out-of-range levels, memory-walked levels and the shift/width of each slot are therefore distinguished, and a swapped or mis-sized configuration slot shows up as a wrong request address. Huge directory entries are tried at every level with a clear and with a pre-filled level field. Leaf steps cover even and odd halves of ordinary entries across the same addresses, which exposes a missing bit-0 clear or a missing odd increment. They also cover huge entries at levels 1 to 3 with the huge-global flag both clear and set. Memory words carry set bits above the physical width so that a missing mask is visible, and requests are stalled and responses delayed by varying amounts to exercise the handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int DATA_W      = 64;
    localparam int PS_W        = 6;
    localparam int BIT_HUGE    = 6;
    localparam int BIT_GLOBAL  = 6;
    localparam int BIT_HGLOBAL = 12;
    localparam int LVLF_LO     = 13;
    localparam int LVLF_W      = 2;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_state_e;

    typedef enum logic {
        KIND_DIR  = 1'b0,
        KIND_LEAF = 1'b1
    } step_kind_e;

    typedef struct packed {
        step_kind_e      kind;
        logic            odd;
        logic [PS_W-1:0] ps;
    } pend_t;

    function automatic word_t low_mask(input int unsigned n);
        if (n >= DATA_W) return '1;
        return (word_t'(1) << n) - word_t'(1);
    endfunction

    function automatic word_t strip_huge(input word_t e);
        word_t r;
        r = e;
        r[BIT_HUGE] = 1'b0;
        r[LVLF_LO +: LVLF_W] = '0;
        if (e[BIT_HGLOBAL]) begin
            r[BIT_HGLOBAL] = 1'b0;
            r[BIT_GLOBAL]  = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
    import ptw_pkg::*;
#(
    parameter int VA_W  = 48,
    parameter int NLVL  = 4,
    parameter int LVL_W = 3
) (
    input  logic [VA_W-1:0]          va,
    input  logic [LVL_W-1:0]         sel,
    input  logic [(NLVL+1)*PS_W-1:0] shift_cfg,
    input  logic [(NLVL+1)*PS_W-1:0] width_cfg,
    output word_t                    idx
);
    logic [PS_W-1:0] shift_a [NLVL+1];
    logic [PS_W-1:0] width_a [NLVL+1];

    for (genvar g = 0; g <= NLVL; g++) begin : g_unpack
        assign shift_a[g] = shift_cfg[g*PS_W +: PS_W];
        assign width_a[g] = width_cfg[g*PS_W +: PS_W];
    end

    logic [PS_W-1:0] sh, wd;
    always_comb begin
        sh = '0;
        wd = '0;
        for (int i = 0; i <= NLVL; i++) begin
            if (sel == LVL_W'(i)) begin
                sh = shift_a[i];
                wd = width_a[i];
            end
        end
        idx = (word_t'(va) >> sh) & low_mask(int'(wd));
    end
endmodule

// File: rtl/ptw_entry_fmt.sv
module ptw_entry_fmt
    import ptw_pkg::*;
#(
    parameter int PA_W  = 48,
    parameter int NLVL  = 4,
    parameter int LVL_W = 3
) (
    input  word_t                    base,
    input  logic [LVL_W-1:0]         level,
    input  logic                     odd,
    input  logic [(NLVL+1)*PS_W-1:0] shift_cfg,
    input  logic [(NLVL+1)*PS_W-1:0] width_cfg,
    output word_t                    dir_tagged,
    output word_t                    leaf_half,
    output logic [PS_W-1:0]          leaf_ps
);
    localparam word_t PA_MASK = low_mask(PA_W);

    word_t            base_pa, stripped;
    logic [LVLF_W-1:0] elvl;
    logic [PS_W-1:0]  sh, wd;

    always_comb begin
        dir_tagged = base;
        if (base[LVLF_LO +: LVLF_W] == '0)
            dir_tagged[LVLF_LO +: LVLF_W] = level[LVLF_W-1:0];

        base_pa  = base & PA_MASK;
        elvl     = base_pa[LVLF_LO +: LVLF_W];
        stripped = strip_huge(base_pa);
        sh = '0;
        wd = '0;
        for (int i = 0; i <= NLVL; i++) begin
            if (32'(elvl) == i) begin
                sh = shift_cfg[i*PS_W +: PS_W];
                wd = width_cfg[i*PS_W +: PS_W];
            end
        end
        leaf_ps   = sh + wd - PS_W'(1);
        leaf_half = odd ? stripped + (word_t'(1) << leaf_ps) : stripped;
    end
endmodule

// File: rtl/ptw_walk_ctrl.sv
module ptw_walk_ctrl
    import ptw_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_fire,
    input  logic            cmd_imm,
    input  word_t           imm_val,
    input  step_kind_e      cmd_kind,
    input  logic            cmd_odd,
    input  logic [PS_W-1:0] cmd_ps,
    input  logic [PA_W-1:0] cmd_addr,
    output logic            idle,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  word_t           mem_rsp_data,
    output logic            done,
    output word_t           res_data,
    output word_t           refill_even,
    output word_t           refill_odd,
    output logic [PS_W-1:0] refill_ps
);
    localparam word_t PA_MASK = low_mask(PA_W);

    walk_state_e state;
    pend_t       pend;

    logic            wr_en, wr_odd;
    word_t           wr_val;
    logic [PS_W-1:0] wr_ps;

    assign idle          = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_REQ);

    always_comb begin
        wr_en  = 1'b0;
        wr_odd = 1'b0;
        wr_val = '0;
        wr_ps  = '0;
        if (state == ST_IDLE && cmd_fire && cmd_imm && cmd_kind == KIND_LEAF) begin
            wr_en  = 1'b1;
            wr_odd = cmd_odd;
            wr_val = imm_val;
            wr_ps  = cmd_ps;
        end else if (state == ST_WAIT && mem_rsp_valid && pend.kind == KIND_LEAF) begin
            wr_en  = 1'b1;
            wr_odd = pend.odd;
            wr_val = mem_rsp_data & PA_MASK;
            wr_ps  = pend.ps;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            pend         <= '0;
            mem_req_addr <= '0;
            done         <= 1'b0;
            res_data     <= '0;
            refill_even  <= '0;
            refill_odd   <= '0;
            refill_ps    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (cmd_fire) begin
                    if (cmd_imm) begin
                        done     <= 1'b1;
                        res_data <= imm_val;
                    end else begin
                        state        <= ST_REQ;
                        mem_req_addr <= cmd_addr;
                        pend         <= '{kind: cmd_kind, odd: cmd_odd, ps: cmd_ps};
                    end
                end
                ST_REQ: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    done     <= 1'b1;
                    res_data <= mem_rsp_data & PA_MASK;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
            if (wr_en) begin
                if (wr_odd) refill_odd  <= wr_val;
                else        refill_even <= wr_val;
                refill_ps <= wr_ps;
            end
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!idle) |-> (!done)); // R8
    AST_RSP_MASKED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT && mem_rsp_valid) |=> (done && ((res_data & ~PA_MASK) == '0))); // R3
    AST_DIR_KEEPS_REFILL: assert property (@(posedge clk) disable iff (rst)
        (idle && cmd_fire && cmd_imm && cmd_kind == KIND_DIR)
        |=> ($stable(refill_even) && $stable(refill_odd))); // R7
endmodule

// File: rtl/ptw_step_unit.sv
module ptw_step_unit
    import ptw_pkg::*;
#(
    parameter int PA_W  = 48,
    parameter int VA_W  = 48,
    parameter int NLVL  = 4,
    parameter int LVL_W = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic                     cmd_leaf,
    input  logic [63:0]              cmd_base,
    input  logic [LVL_W-1:0]         cmd_level,
    input  logic                     cmd_odd,
    input  logic [VA_W-1:0]          fault_va,
    input  logic [(NLVL+1)*6-1:0]    lvl_shift_cfg,
    input  logic [(NLVL+1)*6-1:0]    lvl_width_cfg,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic [PA_W-1:0]          mem_req_addr,
    input  logic                     mem_rsp_valid,
    input  logic [63:0]              mem_rsp_data,
    output logic                     done,
    output logic [63:0]              res_data,
    output logic [63:0]              refill_even,
    output logic [63:0]              refill_odd,
    output logic [5:0]               refill_ps
);
    localparam word_t PA_MASK = low_mask(PA_W);

    logic            lvl_ok, is_huge, imm, fire, idle;
    logic [LVL_W-1:0] idx_sel;
    word_t           idx_raw, idx_use, dir_tagged, leaf_half, imm_val, addr_full;
    logic [PS_W-1:0] huge_ps, step_ps;
    step_kind_e      kind;

    assign kind    = cmd_leaf ? KIND_LEAF : KIND_DIR;
    assign lvl_ok  = (cmd_level != '0) && (cmd_level <= LVL_W'(NLVL));
    assign is_huge = cmd_base[BIT_HUGE];
    assign idx_sel = cmd_leaf ? '0 : cmd_level;

    ptw_index_gen #(.VA_W(VA_W), .NLVL(NLVL), .LVL_W(LVL_W)) u_idx (
        .va(fault_va), .sel(idx_sel), .shift_cfg(lvl_shift_cfg),
        .width_cfg(lvl_width_cfg), .idx(idx_raw)
    );

    ptw_entry_fmt #(.PA_W(PA_W), .NLVL(NLVL), .LVL_W(LVL_W)) u_fmt (
        .base(cmd_base), .level(cmd_level), .odd(cmd_odd),
        .shift_cfg(lvl_shift_cfg), .width_cfg(lvl_width_cfg),
        .dir_tagged(dir_tagged), .leaf_half(leaf_half), .leaf_ps(huge_ps)
    );

    always_comb begin
        if (cmd_leaf) begin
            imm     = is_huge;
            imm_val = leaf_half;
            step_ps = is_huge ? huge_ps : lvl_shift_cfg[PS_W-1:0];
            idx_use = {idx_raw[DATA_W-1:1], 1'b0} + word_t'(cmd_odd);
        end else begin
            imm     = !lvl_ok || is_huge;
            imm_val = (!lvl_ok || cmd_level == LVL_W'(NLVL)) ? cmd_base : dir_tagged;
            step_ps = '0;
            idx_use = idx_raw;
        end
        addr_full = (cmd_base & PA_MASK) | (idx_use << 3);
    end

    assign cmd_ready = idle;
    assign fire      = cmd_valid && idle;

    ptw_walk_ctrl #(.PA_W(PA_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_fire(fire), .cmd_imm(imm), .imm_val(imm_val),
        .cmd_kind(kind), .cmd_odd(cmd_odd), .cmd_ps(step_ps),
        .cmd_addr(addr_full[PA_W-1:0]), .idle(idle),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .res_data(res_data),
        .refill_even(refill_even), .refill_odd(refill_odd), .refill_ps(refill_ps)
    );

    AST_DIR_PASS: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd_leaf && !lvl_ok) |=> (done && res_data == $past(cmd_base))); // R1
    AST_DIR_TAG: assert property (@(posedge clk) disable iff (rst)
        (fire && !cmd_leaf && is_huge && lvl_ok && cmd_level != LVL_W'(NLVL))
        |=> (done && !mem_req_valid && res_data[LVLF_LO +: LVLF_W] != '0)); // R2
endmodule

// File: tb/ptw_step_unit_tb_top.sv
module ptw_step_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int PA_W = 48;
    localparam int VA_W = 48;
    localparam int NLVL = 4;
    localparam logic [63:0] PAM = (64'd1 << PA_W) - 1;

    int S [5] = '{12, 21, 30, 40, 47};
    int W [5] = '{8, 9, 10, 9, 1};

    logic clk = 0, rst = 1;
    logic cmd_valid = 0, cmd_ready, cmd_leaf = 0, cmd_odd = 0;
    logic [63:0] cmd_base = 0;
    logic [2:0] cmd_level = 0;
    logic [VA_W-1:0] fault_va = 0;
    logic [29:0] shift_cfg, width_cfg;
    logic mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
    logic [PA_W-1:0] mem_req_addr;
    logic [63:0] mem_rsp_data = 0;
    logic done;
    logic [63:0] res_data, refill_even, refill_odd;
    logic [5:0] refill_ps;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_step_unit dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_leaf(cmd_leaf), .cmd_base(cmd_base), .cmd_level(cmd_level),
        .cmd_odd(cmd_odd), .fault_va(fault_va), .lvl_shift_cfg(shift_cfg),
        .lvl_width_cfg(width_cfg), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .res_data(res_data), .refill_even(refill_even),
        .refill_odd(refill_odd), .refill_ps(refill_ps)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_word(input logic [PA_W-1:0] a);
        return {a[15:0] ^ 16'hBEEF, a ^ 48'h0000_0A5C_3F00};
    endfunction

    function automatic logic [63:0] idx_of(input logic [VA_W-1:0] va, input int l);
        return (64'(va) >> S[l]) & ((64'd1 << W[l]) - 1);
    endfunction

    function automatic logic [63:0] huge_leaf(input logic [63:0] base, input logic odd,
                                              output int ps);
        logic [63:0] b;
        int lv;
        b  = base & PAM;
        lv = int'(b[14:13]);
        ps = S[lv] + W[lv] - 1;
        if (b[12]) begin b[12] = 0; b[6] = 1; end else b[6] = 0;
        b[14:13] = 0;
        if (odd) b = b + (64'd1 << ps);
        return b;
    endfunction

    task automatic run(input logic leaf, input logic [63:0] base, input logic [2:0] lvl,
                       input logic odd, input logic [VA_W-1:0] va, input int stall,
                       input int rdly, output logic got_req,
                       output logic [PA_W-1:0] raddr, output logic [63:0] res);
        @(negedge clk);
        chk("R8 ready when idle", 64'(cmd_ready), 64'd1);
        cmd_leaf = leaf; cmd_base = base; cmd_level = lvl; cmd_odd = odd;
        fault_va = va; cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        got_req = 0; raddr = '0; res = '0;
        if (done) begin
            res = res_data;
        end else if (mem_req_valid) begin
            got_req = 1;
            raddr = mem_req_addr;
            for (int i = 0; i < stall; i++) begin
                chk("R8 request held", {15'd0, mem_req_valid, mem_req_addr}, {16'd1, raddr});
                @(negedge clk);
            end
            mem_req_ready = 1;
            @(negedge clk);
            mem_req_ready = 0;
            for (int i = 0; i < rdly; i++) begin
                chk("R8 no early done", 64'({done, cmd_ready}), 64'd0);
                @(negedge clk);
            end
            mem_rsp_valid = 1;
            mem_rsp_data = mem_word(raddr);
            @(negedge clk);
            mem_rsp_valid = 0;
            chk("R3 done after response", 64'(done), 64'd1);
            res = res_data;
        end else begin
            chk("R8 neither done nor request", 64'd0, 64'd1);
        end
    endtask

    initial begin
        for (int l = 0; l < 5; l++) begin
            shift_cfg[l*6 +: 6] = 6'(S[l]);
            width_cfg[l*6 +: 6] = 6'(W[l]);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic g;
        logic [PA_W-1:0] a;
        logic [63:0] r, e, prev_even;
        logic [VA_W-1:0] vas [4];
        int ps;
        vas = '{48'h0, 48'hFFFF_FFFF_FFFF, 48'h5A5A_1234_9876, 48'h8000_0040_3FFF};

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9 reset state
        chk("R9 cmd_ready", 64'(cmd_ready), 64'd1);
        chk("R9 done/req", 64'({done, mem_req_valid}), 64'd0);
        chk("R9 res_data", res_data, 64'd0);
        chk("R9 refill_even", refill_even, 64'd0);
        chk("R9 refill_odd", refill_odd, 64'd0);
        chk("R9 refill_ps", 64'(refill_ps), 64'd0);

        // Directory sweep: R1 passthrough, R3 memory walk
        for (int v = 0; v < 4; v++) begin
            for (int l = 0; l < 8; l++) begin
                logic [63:0] base;
                base = 64'hFFFF_0000_0012_3000 ^ (64'(v) << 20);
                run(0, base, 3'(l), 0, vas[v], (v + l) % 3, l % 2, g, a, r);
                if (l == 0 || l > NLVL) begin
                    chk("R1 no request", 64'(g), 64'd0);
                    chk("R1 passthrough", r, base);
                end else begin
                    chk("R3 request issued", 64'(g), 64'd1);
                    e = (base & PAM) | (idx_of(vas[v], l) << 3);
                    chk("R3 dir address", 64'(a), e & PAM);
                    chk("R3 masked result", r, mem_word(a) & PAM);
                end
            end
        end

        // Huge directory entries: R2
        for (int l = 0; l < 8; l++) begin
            logic [63:0] b0, b1;
            b0 = 64'hFFFF_1234_5678_0040;
            b1 = 64'hFFFF_1234_5678_4040;
            run(0, b0, 3'(l), 0, vas[2], 0, 0, g, a, r);
            e = b0;
            if (l >= 1 && l < NLVL) e[14:13] = 2'(l);
            chk("R2 huge no request", 64'(g), 64'd0);
            chk("R2 huge tag", r, e);
            run(0, b1, 3'(l), 0, vas[2], 0, 0, g, a, r);
            chk("R2 level field kept", r, b1);
        end

        // Non-huge leaf: R4, R7
        for (int v = 0; v < 4; v++) begin
            logic [63:0] base;
            base = 64'hF00F_0001_2340_0000 | (64'(v) << 16);
            run(1, base, 3'd0, 0, vas[v], v % 2, v % 3, g, a, r);
            e = (base & PAM) | ((idx_of(vas[v], 0) & ~64'd1) << 3);
            chk("R4 even address", 64'(a), e & PAM);
            chk("R4 even result", r, mem_word(a) & PAM);
            chk("R7 even refill", refill_even, r);
            chk("R4 leaf ps", 64'(refill_ps), 64'(S[0]));
            prev_even = r;
            run(1, base, 3'd0, 1, vas[v], 2, 1, g, a, r);
            e = (base & PAM) | (((idx_of(vas[v], 0) & ~64'd1) + 1) << 3);
            chk("R4 odd address", 64'(a), e & PAM);
            chk("R7 odd refill", refill_odd, mem_word(a) & PAM);
            chk("R7 even untouched", refill_even, prev_even);
        end

        // Huge leaf: R5, R6, R7
        for (int lv = 1; lv < 4; lv++) begin
            for (int gl = 0; gl < 2; gl++) begin
                for (int od = 0; od < 2; od++) begin
                    logic [63:0] base;
                    base = 64'hABCD_0030_0000_0000 | (64'(lv) << 13) | (64'(gl) << 12) | 64'h40 | 64'h5;
                    run(1, base, 3'd0, od[0], vas[1], 0, 0, g, a, r);
                    e = huge_leaf(base, od[0], ps);
                    chk("R5 huge leaf no request", 64'(g), 64'd0);
                    chk("R6 huge leaf value", r, e);
                    chk("R6 huge leaf ps", 64'(refill_ps), 64'(ps));
                    chk("R7 huge refill", od ? refill_odd : refill_even, e);
                end
            end
        end

        // Directory steps leave refill untouched: R7
        prev_even = refill_even;
        e = refill_odd;
        run(0, 64'h0000_0000_0012_3000, 3'd2, 0, vas[3], 1, 1, g, a, r);
        run(0, 64'h0000_0000_0012_3040, 3'd1, 0, vas[3], 0, 0, g, a, r);
        chk("R7 dir keeps even", refill_even, prev_even);
        chk("R7 dir keeps odd", refill_odd, e);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule